// File: doc/BRIEF.md
# Half-Rate Clock and One-Wait-State Acknowledge Generator

This block divides a fast input clock by two and, from the same fast clock, produces an active-low data-transfer acknowledge for a memory controller that needs one wait state on each RAM access. The controller sends in an active-low RAM select and a DMA-acknowledge flag. The select travels through a short shift register that advances only on the falling edges of the divided clock. As a result, the acknowledge reaches the controller one divided-clock cycle later than a zero-wait memory would give it, and each access grows from two divided clocks to three.

Every flop runs on the fast clock. The divided clock is a registered output. A "falling edge of the divided clock" is the fast-clock edge at which that register goes from 1 to 0, and that edge serves as the clock enable for the pipeline. The first pipeline stage is brought out as a test output. An auxiliary clock input is passed to one output unchanged and to a second output inverted.

Top module: `halfclk_ack_gen`

## Requirements
- R1: Once the master reset is high, the divided clock `half_clk` inverts on every rising edge of `clk_fast`. It is 0 after the first edge following reset release, so it has half the input frequency and a 50% duty cycle.
- R2: A rising edge of `clk_fast` with `mst_rst_n` low sets `half_clk`, `ack_n` and `tst_q` to 1. They stay at 1 for as long as reset is held.
- R3: While `dma_ack` is 1, `ack_n` is 1 whatever `ram_sel_n` and the pipeline hold.
- R4: At a fast-clock edge where `half_clk` is 1 before the edge (a divided-clock falling edge), `tst_q` takes the value of `ram_sel_n`. At every other edge `tst_q` holds.
- R5: At a divided-clock falling edge, the second stage takes the value `tst_q` had before the edge. With `dma_ack` at 0, `ack_n` equals that second stage.
- R6: With `dma_ack` at 0 before and after an edge, `ack_n` changes only at divided-clock falling edges.
- R7: When `ram_sel_n` drops to 0 and stays there, `ack_n` first goes to 0 on the second divided-clock falling edge that samples the low select.
- R8: When `ram_sel_n` returns to 1, `ack_n` goes back to 1 on the second divided-clock falling edge that samples the high level. A following access receives its own fresh one-cycle delay.
- R9: `aux_buf` equals `aux_clk` and `aux_inv` is its inverse, with no clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock; all flops use its rising edge |
| mst_rst_n | input | 1 | Master reset, active low, synchronous; presets outputs high |
| ram_sel_n | input | 1 | RAM select from the memory controller, active low |
| dma_ack | input | 1 | DMA acknowledge; 1 forces `ack_n` high |
| aux_clk | input | 1 | Auxiliary clock to be passed through |
| half_clk | output | 1 | Divided clock, half the frequency of `clk_fast` |
| ack_n | output | 1 | Data-transfer acknowledge, active low, delayed by one wait state |
| tst_q | output | 1 | First pipeline stage (sampled select level) |
| aux_buf | output | 1 | `aux_clk` passed through unchanged |
| aux_inv | output | 1 | `aux_clk` inverted |

## Verification
The pipeline is driven with four kinds of input: a random select and DMA flag on every fast cycle, a slowly toggling select with DMA held low, a reset pulse in the middle of activity, and directed single select edges. The random sweep separates the two stages and the DMA override, because a change that does not land on a falling-edge boundary must not move either stage. The slow toggles show whether the acknowledge moves only on falling edges. The directed edges count divided-clock falls from the select change to the acknowledge change, in both directions. A count of two tells a correct pipeline apart from one with a missing or an extra stage. Back-to-back accesses are covered by select pulses that last a single divided cycle.

// File: rtl/halfclk_ack_pkg.sv
package halfclk_ack_pkg;

    localparam int unsigned ACK_STAGES_DEF = 2;

    typedef struct packed {
        logic half;
        logic fall_en;
    } half_state_t;

    typedef enum logic {
        LVL_ASSERTED   = 1'b0,
        LVL_DEASSERTED = 1'b1
    } act_low_e;

    function automatic logic next_half(input logic rst_n, input logic cur);
        return rst_n ? ~cur : 1'b1;
    endfunction

    function automatic logic ack_override(input logic stage_lvl, input logic dma);
        return dma ? LVL_DEASSERTED : stage_lvl;
    endfunction

endpackage

// File: rtl/half_divider.sv
module half_divider
    import halfclk_ack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output half_state_t st
);
    logic half_q;

    always_ff @(posedge clk) begin
        half_q <= next_half(rst_n, half_q);
    end

    // The register is 1 now, so this edge takes it to 0: a divided-clock fall.
    always_comb begin
        st.half    = half_q;
        st.fall_en = half_q & rst_n;
    end
endmodule

// File: rtl/sel_shift.sv
module sel_shift #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              din,
    output logic [STAGES-1:0] q
);
    localparam logic [STAGES-1:0] PRESET = '1;

    logic [STAGES-1:0] sh;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic d_in;
        if (g == 0) begin : g_head
            assign d_in = din;
        end else begin : g_body
            assign d_in = sh[g-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh[g] <= PRESET[g];
            end else if (en) begin
                sh[g] <= d_in;
            end
        end
    end

    assign q = sh;
endmodule

// File: rtl/aux_pass.sv
module aux_pass (
    input  logic a,
    output logic y,
    output logic y_n
);
    assign y   = a;
    assign y_n = ~a;
endmodule

// File: rtl/halfclk_ack_gen.sv
module halfclk_ack_gen
    import halfclk_ack_pkg::*;
#(
    parameter int unsigned ACK_STAGES = ACK_STAGES_DEF
) (
    input  logic clk_fast,
    input  logic mst_rst_n,
    input  logic ram_sel_n,
    input  logic dma_ack,
    input  logic aux_clk,
    output logic half_clk,
    output logic ack_n,
    output logic tst_q,
    output logic aux_buf,
    output logic aux_inv
);
    localparam int unsigned LAST = ACK_STAGES - 1;

    half_state_t       hs;
    logic [LAST:0]     pipe;

    half_divider u_div (
        .clk   (clk_fast),
        .rst_n (mst_rst_n),
        .st    (hs)
    );

    sel_shift #(.STAGES(ACK_STAGES)) u_shift (
        .clk   (clk_fast),
        .rst_n (mst_rst_n),
        .en    (hs.fall_en),
        .din   (ram_sel_n),
        .q     (pipe)
    );

    aux_pass u_aux (
        .a   (aux_clk),
        .y   (aux_buf),
        .y_n (aux_inv)
    );

    assign half_clk = hs.half;
    assign tst_q    = pipe[0];
    assign ack_n    = ack_override(pipe[LAST], dma_ack);
endmodule

// File: rtl/halfclk_ack_chk.sv
module halfclk_ack_chk #(
    parameter int unsigned ACK_STAGES = 2
) (
    input logic clk_fast,
    input logic mst_rst_n,
    input logic ram_sel_n,
    input logic dma_ack,
    input logic half_clk,
    input logic ack_n,
    input logic tst_q
);
    assert_reset_preset_R2: assert property (@(posedge clk_fast)
        !mst_rst_n |=> (half_clk && ack_n && tst_q));

    assert_half_toggle_R1: assert property (@(posedge clk_fast) disable iff (!mst_rst_n)
        mst_rst_n |=> (half_clk != $past(half_clk)));

    assert_dma_force_R3: assert property (@(posedge clk_fast) disable iff (!mst_rst_n)
        dma_ack |-> ack_n);

    assert_first_stage_R4: assert property (@(posedge clk_fast) disable iff (!mst_rst_n)
        (mst_rst_n && half_clk) |=> (tst_q == $past(ram_sel_n)));

    assert_stage_hold_R4: assert property (@(posedge clk_fast) disable iff (!mst_rst_n)
        (mst_rst_n && !half_clk) |=> $stable(tst_q));

    assert_ack_only_on_fall_R6: assert property (@(posedge clk_fast) disable iff (!mst_rst_n)
        (mst_rst_n && !half_clk && !dma_ack) |=> (dma_ack || $stable(ack_n)));

    if (ACK_STAGES == 2) begin : g_two
        assert_second_stage_R5: assert property (@(posedge clk_fast) disable iff (!mst_rst_n)
            (mst_rst_n && half_clk) |=> (dma_ack || ack_n == $past(tst_q)));
    end
endmodule

bind halfclk_ack_gen halfclk_ack_chk #(.ACK_STAGES(ACK_STAGES)) u_chk (
    .clk_fast  (clk_fast),
    .mst_rst_n (mst_rst_n),
    .ram_sel_n (ram_sel_n),
    .dma_ack   (dma_ack),
    .half_clk  (half_clk),
    .ack_n     (ack_n),
    .tst_q     (tst_q)
);

// File: tb/sim_halfclk_ack_gen.sv
`timescale 1ns/1ps
module sim_halfclk_ack_gen;
    logic clk = 1'b0;
    logic rst_n, sel_n, dma, aux;
    logic half, ackn, tst, abuf, ainv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model, built from the requirements
    logic m_half, m_s0, m_s1;
    bit   valid = 1'b0;
    logic prev_half, prev_ack, prev_dma;

    always #2.5 clk = ~clk;

    halfclk_ack_gen u0 (
        .clk_fast  (clk),
        .mst_rst_n (rst_n),
        .ram_sel_n (sel_n),
        .dma_ack   (dma),
        .aux_clk   (aux),
        .half_clk  (half),
        .ack_n     (ackn),
        .tst_q     (tst),
        .aux_buf   (abuf),
        .aux_inv   (ainv)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // one fast cycle: inputs set now (at a falling clk edge), model advanced at
    // the rising edge, outputs checked at the next falling edge
    task automatic cycle(input logic r, input logic s, input logic d, input logic a);
        logic fell;
        rst_n = r; sel_n = s; dma = d; aux = a;
        #0.5;
        chk("R9 aux_buf", abuf, a);
        chk("R9 aux_inv", ainv, ~a);
        @(posedge clk);
        if (!r) begin
            m_half = 1'b1; m_s0 = 1'b1; m_s1 = 1'b1; valid = 1'b1;
        end else if (valid) begin
            if (m_half) begin
                m_s1 = m_s0;
                m_s0 = s;
            end
            m_half = ~m_half;
        end
        @(negedge clk);
        if (valid) begin
            fell = prev_half && !half;
            if (!r) begin
                chk("R2 half preset", half, 1'b1);
                chk("R2 ack preset", ackn, 1'b1);
                chk("R2 tst preset", tst, 1'b1);
            end else begin
                chk("R1 half", half, m_half);
                chk("R4 tst", tst, m_s0);
                chk("R5 ack", ackn, m_s1 | d);
                if (d) chk("R3 dma force", ackn, 1'b1);
                if (!fell && !d && !prev_dma && r) chk("R6 ack stable", ackn, prev_ack);
            end
        end
        prev_half = half; prev_ack = ackn; prev_dma = d;
    endtask

    // hold select at a level and count divided-clock falls until ack follows
    task automatic latency(input string req, input logic lvl);
        int falls = 0;
        int seen  = -1;
        for (int k = 0; k < 12; k++) begin
            logic ph;
            ph = prev_half;
            cycle(1'b1, lvl, 1'b0, k[0]);
            if (ph && !half) falls++;
            if (seen < 0 && ackn == lvl) seen = falls;
        end
        checks++;
        if (seen != 2) begin
            fails++;
            $display("FAIL %s actual=%0d expected=2 falls", req, seen);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; dma = 1'b0; aux = 1'b0;
        prev_half = 1'b1; prev_ack = 1'b1; prev_dma = 1'b0;
        m_half = 1'b1; m_s0 = 1'b1; m_s1 = 1'b1;
        @(negedge clk);
        // R2: reset held with select low and dma toggling
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, i[0], i[1]);
        // R1/R3/R4/R5: random select and dma every cycle
        for (int i = 0; i < 1500; i++)
            cycle(1'b1, 1'($urandom()), 1'($urandom_range(0, 3) == 0), 1'($urandom()));
        // R6: slow select toggles, dma low
        for (int i = 0; i < 400; i++) cycle(1'b1, i[3], 1'b0, i[0]);
        // R2: reset pulse mid-run
        cycle(1'b0, 1'b0, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) cycle(1'b1, i[2], 1'b0, 1'b1);
        // R7/R8: latency in falls, repeated for back-to-back accesses
        for (int j = 0; j < 3; j++) begin
            for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0);
            latency("R7 ack low latency", 1'b0);
            latency("R8 ack release latency", 1'b1);
        end
        // R8: one-divided-cycle select pulses back to back
        for (int i = 0; i < 200; i++) cycle(1'b1, i[1], 1'b0, 1'b0);
        finish_run();
    end
endmodule